// File: doc/BRIEF.md
# Field Delay Memory Write Port

This block is the write-clock-domain controller of a line or field delay memory. It samples a write reset, a write enable, an input-mask enable and a data word on each rising write-clock edge. From these it produces the address, write strobe and write data for a synchronous RAM array of parameterised depth that sits next to it. The delay through the memory is set by when the write side and the read side are reset. This block handles only the write side.

The two enables behave differently. Write enable gates the address pointer: while it is low, the pointer holds and nothing is stored. Input enable only masks the store: while write enable is high, the pointer keeps stepping even when input enable is low, so masked positions in the array keep their old contents. Both enables act through a fixed control latency of four write clocks. An enable sampled at one edge therefore governs the data word sampled four edges later.

A protocol checker watches how the write reset is used. It raises a sticky error flag in three cases:
- write enable was not held low long enough before a reset;
- write enable rose during the recovery interval after a reset;
- a write pass ended with too few stored words.

Top module: `fdm_wr_port`

## Requirements
- R1: While `rst_n` is low, `mem_we`, `mem_addr`, `mem_wdata` and `proto_err` are all 0.
- R2: An edge that samples `wr_rst` high clears the pointer to 0 and produces no strobe. The next stored word goes to address 0.
- R3: `wr_en` and `in_en` sampled at edge n govern the data sampled at edge n+4. After edge n+4, `mem_we` is high exactly when both were high at edge n, and `wr_rst` is low at edge n+4. With `mem_we`, `mem_addr` carries the pointer and `mem_wdata` carries the word sampled at edge n+4.
- R4: When the delayed write enable is low, the pointer holds and `mem_we` stays low.
- R5: When the delayed write enable is high and the delayed input enable is low, `mem_we` stays low but the pointer still advances by one.
- R6: The pointer advances from DEPTH-1 to 0.
- R7: `proto_err` sets after a reset edge if `wr_en` was not low on at least PRE_LOW preceding edges, or if it is high at that reset edge.
- R8: `proto_err` sets if `wr_en` is sampled high on any of the RECOV edges that follow a reset edge.
- R9: At a reset edge that closes a pass opened by an earlier reset, `proto_err` sets if fewer than MIN_ACT words were stored in that pass. A pass with at least MIN_ACT stored words leaves it clear.
- R10: Once set, `proto_err` stays high until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_rst | input | 1 | Synchronous pointer reset |
| wr_en | input | 1 | Write enable: pointer advance and capture |
| in_en | input | 1 | Input enable: store mask |
| din | input | DATA_W | Data word |
| mem_addr | output | ADDR_W | RAM write address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | DATA_W | RAM write data |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with the following parameters:

| Parameter | Value |
|---|---|
| DEPTH | 16 |
| RECOV | 8 |
| MIN_ACT | 6 |
| PRE_LOW | 4 |
| LAT | 4 |

With these values a 20-word burst crosses the wrap point, and each protocol rule can be violated within a few dozen cycles. A 64-cycle sweep walks all four enable combinations in shifting orders, so every enable transition meets the four-cycle latency. Address and data are checked against a pointer model that the bench computes. Each violation kind runs after its own fresh reset, which shows both the setting and the stickiness of the error flag.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // Control pair carried through the latency pipeline.
  typedef struct packed {
    logic we;   // pointer advance / capture
    logic ie;   // store mask
  } fdm_ctl_t;

endpackage

// File: rtl/fdm_rst_sync.sv
module fdm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fdm_ctl_delay.sv
module fdm_ctl_delay
  import fdm_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  fdm_ctl_t ctl_in,
  output fdm_ctl_t ctl_out
);

  fdm_ctl_t stg_q [LAT];
  fdm_ctl_t stg_d [LAT];

  always_comb begin
    stg_d[0] = ctl_in;
    for (int i = 1; i < LAT; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < LAT; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign ctl_out = stg_q[LAT-1];

endmodule

// File: rtl/fdm_addr_gen.sv
module fdm_addr_gen
  import fdm_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  fdm_ctl_t          ctl_eff,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr_event
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              we_q, we_d;
  logic              hit;

  // Wrap variant chosen by whether the depth fills the address space.
  generate
    if ((1 << ADDR_W) == DEPTH) begin : g_pow2
      assign ptr_inc = ptr_q + 1'b1;
    end else begin : g_cmp
      assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    hit    = ctl_eff.we & ctl_eff.ie & ~wr_rst;
    ptr_d  = ptr_q;
    if (wr_rst)          ptr_d = '0;
    else if (ctl_eff.we) ptr_d = ptr_inc;
    we_d   = hit;
    addr_d = addr_q;
    data_d = data_q;
    if (hit) begin
      addr_d = ptr_q;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_wdata = data_q;
  assign wr_event  = hit;

  // R2: pointer is zero after a reset edge
  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> (ptr_q == '0));
  // R4: pointer holds while the delayed write enable is low
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && !ctl_eff.we) |=> $stable(ptr_q));
  // R6: wrap from the last address
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && ctl_eff.we && ptr_q == LAST) |=> (ptr_q == '0));
  // R5: masked cycle advances pointer without strobe
  p_mask_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && ctl_eff.we && !ctl_eff.ie && ptr_q != LAST)
      |=> (!mem_we && ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/fdm_proto_chk.sv
module fdm_proto_chk #(
  parameter int unsigned PRE_LOW = 4,
  parameter int unsigned RECOV   = 128,
  parameter int unsigned MIN_ACT = 231,
  localparam int unsigned LOW_W = $clog2(PRE_LOW + 1),
  localparam int unsigned REC_W = $clog2(RECOV + 1),
  localparam int unsigned ACT_W = $clog2(MIN_ACT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_rst,
  input  logic wr_en,
  input  logic wr_event,
  output logic proto_err
);

  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(PRE_LOW);
  localparam logic [REC_W-1:0] REC_MAX = REC_W'(RECOV);
  localparam logic [ACT_W-1:0] ACT_MAX = ACT_W'(MIN_ACT);

  logic [LOW_W-1:0] low_q, low_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic             open_q, open_d;
  logic             err_q, err_d;
  logic             pre_bad, rec_bad, pass_bad;

  always_comb begin
    pre_bad  = wr_rst & (wr_en | (low_q < LOW_MAX));
    rec_bad  = ~wr_rst & wr_en & (rec_q != '0);
    pass_bad = wr_rst & open_q & (act_q < ACT_MAX);

    if (wr_en)                low_d = '0;
    else if (low_q < LOW_MAX) low_d = low_q + 1'b1;
    else                      low_d = low_q;

    if (wr_rst)            rec_d = REC_MAX;
    else if (rec_q != '0)  rec_d = rec_q - 1'b1;
    else                   rec_d = rec_q;

    if (wr_rst)                           act_d = '0;
    else if (wr_event && act_q < ACT_MAX) act_d = act_q + 1'b1;
    else                                  act_d = act_q;

    open_d = open_q | wr_rst;
    err_d  = err_q | pre_bad | rec_bad | pass_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      rec_q  <= '0;
      act_q  <= '0;
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      low_q  <= low_d;
      rec_q  <= rec_d;
      act_q  <= act_d;
      open_q <= open_d;
      err_q  <= err_d;
    end
  end

  assign proto_err = err_q;

  // R10: error flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R8: recovery counter never exceeds its load value
  p_rec_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_q <= REC_MAX);
  // R8: enable high during recovery raises the flag
  p_rec_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_rst && wr_en && rec_q != '0) |=> proto_err);

endmodule

// File: rtl/fdm_wr_port.sv
module fdm_wr_port
  import fdm_pkg::*;
#(
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned LAT     = 4,
  parameter int unsigned PRE_LOW = 4,
  parameter int unsigned RECOV   = 128,
  parameter int unsigned MIN_ACT = 231,
  localparam int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic              in_en,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              proto_err
);

  logic     rst_sync_n;
  fdm_ctl_t ctl_raw, ctl_eff;
  logic     wr_event;

  assign ctl_raw.we = wr_en;
  assign ctl_raw.ie = in_en;

  fdm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fdm_ctl_delay #(.LAT(LAT)) u_ctl_delay (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctl_in  (ctl_raw),
    .ctl_out (ctl_eff)
  );

  fdm_addr_gen #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_addr_gen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_rst    (wr_rst),
    .ctl_eff   (ctl_eff),
    .din       (din),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .wr_event  (wr_event)
  );

  fdm_proto_chk #(.PRE_LOW(PRE_LOW), .RECOV(RECOV), .MIN_ACT(MIN_ACT)) u_proto_chk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_rst    (wr_rst),
    .wr_en     (wr_en),
    .wr_event  (wr_event),
    .proto_err (proto_err)
  );

  // R2: no strobe results from a reset edge
  p_rst_nostrobe_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_rst |=> !mem_we);

  generate
    if (LAT == 4) begin : g_lat4_chk
      // R3: a strobe traces back to both enables five edges earlier
      p_latency_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        mem_we |-> ($past(wr_en, 5) && $past(in_en, 5)));
    end
  endgenerate

endmodule

// File: tb/fdm_wr_port_bench.sv
module fdm_wr_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 16;
  localparam int DATA_W  = 10;
  localparam int RECOV   = 8;
  localparam int MIN_ACT = 6;
  localparam int PRE_LOW = 4;
  localparam int AW      = 4;

  logic              clk = 1'b0;
  logic              rst_n, wr_rst, wr_en, in_en;
  logic [DATA_W-1:0] din;
  logic [AW-1:0]     mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic              proto_err;

  int nvec = 0;
  int nfail = 0;
  int ncyc = 0;
  bit done = 0;

  // bench model state
  bit          h_we [4];
  bit          h_ie [4];
  int          mptr;
  bit          e_we;
  int          e_addr;
  int          e_dat;
  bit          e_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdm_wr_port #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .LAT(4),
    .PRE_LOW(PRE_LOW), .RECOV(RECOV), .MIN_ACT(MIN_ACT)
  ) u_fdm_wr_port (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en), .in_en(in_en),
    .din(din), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .proto_err(proto_err)
  );

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin h_we[i] = 0; h_ie[i] = 0; end
    mptr = 0; e_we = 0; e_err = 0;
  endtask

  task automatic check(input string tag);
    bit bad = 0;
    nvec++;
    if (mem_we !== e_we) begin
      $display("FAIL %s mem_we act=%0b exp=%0b", tag, mem_we, e_we); bad = 1;
    end
    if (e_we && mem_addr !== AW'(e_addr)) begin
      $display("FAIL %s mem_addr act=%0d exp=%0d", tag, mem_addr, e_addr); bad = 1;
    end
    if (e_we && mem_wdata !== DATA_W'(e_dat)) begin
      $display("FAIL %s mem_wdata act=%0h exp=%0h", tag, mem_wdata, e_dat); bad = 1;
    end
    if (proto_err !== e_err) begin
      $display("FAIL %s proto_err act=%0b exp=%0b", tag, proto_err, e_err); bad = 1;
    end
    if (bad) nfail++;
  endtask

  // One write-clock cycle: drive, model the edge, sample a quarter period later.
  task automatic cyc(input bit we, input bit ie, input bit rs, input bit viol,
                     input string tag);
    int d;
    bit eff_we, eff_ie;
    d = (ncyc * 37 + 5) & 10'h3ff;
    ncyc++;
    wr_en = we; in_en = ie; wr_rst = rs; din = DATA_W'(d);
    eff_we = h_we[3]; eff_ie = h_ie[3];
    for (int i = 3; i > 0; i--) begin h_we[i] = h_we[i-1]; h_ie[i] = h_ie[i-1]; end
    h_we[0] = we; h_ie[0] = ie;
    e_we = eff_we & eff_ie & !rs;
    if (e_we) begin e_addr = mptr; e_dat = d; end
    if (rs) mptr = 0;
    else if (eff_we) mptr = (mptr + 1) % DEPTH;
    if (viol) e_err = 1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  task automatic hw_reset();
    rst_n = 1'b0; wr_rst = 0; wr_en = 0; in_en = 0; din = '0;
    model_clear();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1");
    rst_n = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, "R1");
  endtask

  task automatic open_pass();
    repeat (PRE_LOW) cyc(0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, "R2");
    repeat (RECOV) cyc(0, 0, 0, 0, "R8");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    $display("FAIL watchdog expired");
    nfail++;
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_rst = 0; wr_en = 0; in_en = 0; din = '0;
    #(CLK_PERIOD/4);
    hw_reset();

    // clean first pass; burst crosses the wrap point
    open_pass();
    repeat (20) cyc(1, 1, 0, 0, "R6");
    repeat (4) cyc(0, 0, 0, 0, "R4");
    // masked writes keep stepping the pointer
    for (int k = 0; k < 16; k++) cyc(1, (k % 3) != 0, 0, 0, "R5");
    repeat (4) cyc(0, 0, 0, 0, "R5");
    // write-enable gaps hold the pointer
    for (int k = 0; k < 16; k++) cyc(((k >> 1) & 1) == 0, 1, 0, 0, "R4");
    repeat (4) cyc(0, 0, 0, 0, "R4");
    // sweep of both enables in shifting orders
    for (int k = 0; k < 64; k++) begin
      int m;
      m = k ^ (k >> 2) ^ (k >> 4);
      cyc(m[0], m[1], 0, 0, "R3");
    end
    repeat (4) cyc(0, 0, 0, 0, "R3");
    // reset closing a long pass: no error; pointer restarts at 0
    cyc(0, 0, 1, 0, "R9");
    repeat (RECOV) cyc(0, 0, 0, 0, "R8");
    repeat (8) cyc(1, 1, 0, 0, "R2");
    repeat (4) cyc(0, 0, 0, 0, "R2");

    // pre-reset low period too short
    hw_reset();
    repeat (2) cyc(0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 1, "R7");
    repeat (6) cyc(0, 0, 0, 0, "R10");
    hw_reset();
    cyc(0, 0, 0, 0, "R10");

    // enable raised inside the recovery interval
    hw_reset();
    repeat (PRE_LOW) cyc(0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, "R8");
    repeat (2) cyc(0, 0, 0, 0, "R8");
    cyc(1, 1, 0, 1, "R8");
    repeat (6) cyc(0, 0, 0, 0, "R10");

    // pass with too few stored words
    hw_reset();
    open_pass();
    repeat (3) cyc(1, 1, 0, 0, "R9");
    repeat (4) cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 1, "R9");
    repeat (4) cyc(0, 0, 0, 0, "R10");

    finish_run();
  end

endmodule